// File: doc/BRIEF.md
# Gated Frequency and Period Measurement Counter

This block measures either the frequency of a fast signal or the period of a slow one with a single saturating binary counter. In frequency mode it counts the rising edges of one chosen input while a gate window is open. The window lasts 1, 4, 16 or 64 ticks of a chip-wide 1 ms timebase. In period mode it waits for one full cycle of a logic-level pilot input and counts pulses of a reference strobe during that cycle.

Software, through a register layer outside this block, loads the gate code and the source selection and pulses a start command. Start clears the result and arms the next measurement. Software then polls the busy flag. When busy is low, it reads the result and checks the overflow flag. All three measured inputs are asynchronous and pass through two-flop synchronisers before their edges are detected. The tick and the reference strobe are single-cycle pulses that are already synchronous to the clock.

Top module: `meas_counter`

## Requirements
- R1: After reset, count_o is 0, busy_o is 0 and over_o is 0.
- R2: A start_i pulse clears count_o and over_o and raises busy_o, all visible on the next cycle. This also holds when a measurement is already running, which is then abandoned.
- R3: The gate code g on gate_sel_i (0 to 3) gives a window of 4^g ticks. The window opens on the first tick_1ms_i after start, and busy_o falls in the cycle after the tick that closes the window.
- R4: In frequency mode, count_o is the number of rising edges of the selected input seen while the window is open. Edges that arrive before the window opens, or after it closes, are not counted. An edge is counted within three clock cycles of the pin change.
- R5: In period mode, nothing is counted from the start until the first pilot rising edge after the opening tick. From that edge up to the next pilot rising edge, every ref_pulse_i pulse is counted. The second edge ends the measurement and drops busy_o, and ticks do not end it.
- R6: src_sel_i bit 0 selects the pilot input (period mode), bit 1 selects input A and bit 2 selects input B. Bit 0 has priority over bit 1, and bit 1 has priority over bit 2. With no bit set, the window runs but the count stays 0.
- R7: The count saturates at 2^CNT_W-1 and never wraps. over_o rises on the 2^CNT_W-th event and stays high until the next start.
- R8: When idle, count_o and over_o hold their values whatever the inputs do. gate_sel_i and src_sel_i are sampled only in the start cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle start command: clear and arm |
| gate_sel_i | input | 2 | Gate code g, window of 4^g ticks |
| src_sel_i | input | 3 | Source select: bit0 pilot, bit1 input A, bit2 input B |
| tick_1ms_i | input | 1 | One-cycle 1 ms timebase strobe |
| ref_pulse_i | input | 1 | One-cycle reference strobe counted in period mode |
| freq_a_i | input | 1 | Asynchronous frequency input A |
| freq_b_i | input | 1 | Asynchronous frequency input B |
| pilot_i | input | 1 | Asynchronous slow pilot input for period mode |
| count_o | output | CNT_W | Measured value |
| busy_o | output | 1 | Measurement in progress |
| over_o | output | 1 | Count reached 2^CNT_W |

## Verification
Start takes effect one cycle later: the bench drives it at a falling edge and checks busy, count and overflow at the next falling edge. A tick that closes the window drops busy at the rising edge that samples it, so busy is checked high just before the last tick and low one falling edge after it. Input edges reach the counter three rising edges after the pin change, so the bench keeps at least four idle cycles between any measured edge and a tick or pilot edge that opens or closes a window. Each expected count is therefore an exact number of pulses, computed from how many pulses the bench drove and the saturation limit.

// File: rtl/meas_pkg.sv
package meas_pkg;
  localparam int unsigned SRC_N     = 3;
  localparam int unsigned SRC_PILOT = 0;
  localparam int unsigned SRC_A     = 1;
  localparam int unsigned SRC_B     = 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARM,
    ST_GATE,
    ST_HUNT,
    ST_PERIOD
  } meas_state_e;
endpackage

// File: rtl/meas_edge_sync.sv
module meas_edge_sync #(
  parameter int unsigned N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] din_i,
  output logic [N-1:0] rise_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic s1_q, s2_q, s3_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q <= 1'b0;
        s2_q <= 1'b0;
        s3_q <= 1'b0;
      end else begin
        s1_q <= din_i[i];
        s2_q <= s1_q;
        s3_q <= s2_q;
      end
    end
    assign rise_o[i] = s2_q & ~s3_q;

    a_r4_rise_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rise_o[i] |=> !rise_o[i]);
  end
endmodule

// File: rtl/meas_src_sel.sv
module meas_src_sel
  import meas_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [SRC_N-1:0] sel_i,
  input  logic [SRC_N-1:0] rise_i,
  input  logic             ref_i,
  output logic             period_o,
  output logic             event_o
);
  logic [SRC_N-1:0] sel_q;
  logic [SRC_N-1:0] grant;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sel_q <= '0;
    else if (load_i) sel_q <= sel_i;
  end

  // lowest index wins
  always_comb begin
    logic taken;
    taken = 1'b0;
    grant = '0;
    for (int i = 0; i < int'(SRC_N); i++) begin
      if (sel_q[i] && !taken) begin
        grant[i] = 1'b1;
        taken    = 1'b1;
      end
    end
  end

  assign period_o = grant[SRC_PILOT];
  assign event_o  = period_o ? ref_i : |(grant & rise_i);

  a_r6_single_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant));
  a_r6_pilot_priority: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_q[SRC_PILOT] |-> period_o);
endmodule

// File: rtl/meas_gate_ctrl.sv
module meas_gate_ctrl
  import meas_pkg::*;
#(
  parameter int unsigned GATE_CODE_W    = 2,
  parameter int unsigned GATE_STEP_LOG2 = 2
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   start_i,
  input  logic [GATE_CODE_W-1:0] gate_code_i,
  input  logic                   tick_i,
  input  logic                   period_i,
  input  logic                   pilot_rise_i,
  output logic                   busy_o,
  output logic                   count_en_o
);
  localparam int unsigned MAX_TICKS = 1 << (GATE_STEP_LOG2 * ((1 << GATE_CODE_W) - 1));
  localparam int unsigned TW        = $clog2(MAX_TICKS + 1);

  meas_state_e            state_q;
  logic [GATE_CODE_W-1:0] code_q;
  logic [TW-1:0]          remain_q;

  function automatic logic [TW-1:0] gate_len(input logic [GATE_CODE_W-1:0] c);
    logic [TW-1:0] one;
    one = {{(TW-1){1'b0}}, 1'b1};
    return one << (GATE_STEP_LOG2 * int'(c));
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      code_q   <= '0;
      remain_q <= '0;
    end else if (start_i) begin
      state_q <= ST_ARM;
      code_q  <= gate_code_i;
    end else begin
      unique case (state_q)
        ST_ARM: if (tick_i) begin
          if (period_i) state_q <= ST_HUNT;
          else begin
            state_q  <= ST_GATE;
            remain_q <= gate_len(code_q);
          end
        end
        ST_GATE: if (tick_i) begin
          if (remain_q == TW'(1)) state_q <= ST_IDLE;
          remain_q <= remain_q - TW'(1);
        end
        ST_HUNT:   if (pilot_rise_i) state_q <= ST_PERIOD;
        ST_PERIOD: if (pilot_rise_i) state_q <= ST_IDLE;
        default: ;
      endcase
    end
  end

  assign busy_o     = (state_q != ST_IDLE);
  assign count_en_o = (state_q == ST_GATE) || (state_q == ST_PERIOD);

  a_r3_arm_waits_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ARM && !tick_i && !start_i) |=> state_q == ST_ARM);
  a_r3_gate_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_GATE && !tick_i && !start_i) |=> state_q == ST_GATE);
  a_r3_remain_live: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_GATE |-> remain_q != '0);
  a_r5_period_ignores_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_PERIOD && !pilot_rise_i && !start_i) |=> state_q == ST_PERIOD);
endmodule

// File: rtl/meas_accum.sv
module meas_accum #(
  parameter int unsigned W = 20
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] count_o,
  output logic         over_o
);
  localparam logic [W-1:0] MAX = '1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_o <= '0;
      over_o  <= 1'b0;
    end else if (clr_i) begin
      count_o <= '0;
      over_o  <= 1'b0;
    end else if (inc_i) begin
      if (count_o == MAX) over_o  <= 1'b1;
      else                count_o <= count_o + W'(1);
    end
  end

  a_r2_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (count_o == '0) && !over_o);
  a_r7_over_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (over_o && !clr_i) |=> over_o);
  a_r7_over_at_max: assert property (@(posedge clk_i) disable iff (!rst_ni)
    over_o |-> count_o == MAX);
  a_r7_no_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_o == MAX && !clr_i) |=> count_o == MAX);
endmodule

// File: rtl/meas_counter.sv
module meas_counter
  import meas_pkg::*;
#(
  parameter int unsigned CNT_W          = 20,
  parameter int unsigned GATE_CODE_W    = 2,
  parameter int unsigned GATE_STEP_LOG2 = 2
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   start_i,
  input  logic [GATE_CODE_W-1:0] gate_sel_i,
  input  logic [SRC_N-1:0]       src_sel_i,
  input  logic                   tick_1ms_i,
  input  logic                   ref_pulse_i,
  input  logic                   freq_a_i,
  input  logic                   freq_b_i,
  input  logic                   pilot_i,
  output logic [CNT_W-1:0]       count_o,
  output logic                   busy_o,
  output logic                   over_o
);
  logic [SRC_N-1:0] pins, rise;
  logic             period, event_hit, count_en;

  always_comb begin
    pins            = '0;
    pins[SRC_PILOT] = pilot_i;
    pins[SRC_A]     = freq_a_i;
    pins[SRC_B]     = freq_b_i;
  end

  meas_edge_sync #(.N(SRC_N)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .din_i  (pins),
    .rise_o (rise)
  );

  meas_src_sel i_src (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (start_i),
    .sel_i    (src_sel_i),
    .rise_i   (rise),
    .ref_i    (ref_pulse_i),
    .period_o (period),
    .event_o  (event_hit)
  );

  meas_gate_ctrl #(
    .GATE_CODE_W    (GATE_CODE_W),
    .GATE_STEP_LOG2 (GATE_STEP_LOG2)
  ) i_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .gate_code_i  (gate_sel_i),
    .tick_i       (tick_1ms_i),
    .period_i     (period),
    .pilot_rise_i (rise[SRC_PILOT]),
    .busy_o       (busy_o),
    .count_en_o   (count_en)
  );

  meas_accum #(.W(CNT_W)) i_acc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (start_i),
    .inc_i   (count_en & event_hit),
    .count_o (count_o),
    .over_o  (over_o)
  );

  a_r2_start_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> busy_o);
  a_r8_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> $stable(count_o) && $stable(over_o));
endmodule

// File: tb/test_meas_counter.sv
`timescale 1ns/1ps
module test_meas_counter;
  localparam int W   = 8;
  localparam int MAX = (1 << W) - 1;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [1:0] gsel = '0;
  logic [2:0] ssel = '0;
  logic       tick = 1'b0, refp = 1'b0, fa = 1'b0, fb = 1'b0, pil = 1'b0;
  logic [W-1:0] count;
  logic       busy, over;
  int errors = 0, checks = 0;

  always #2.5 clk = ~clk;

  meas_counter #(.CNT_W(W)) i_meas_counter (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .gate_sel_i(gsel),
    .src_sel_i(ssel), .tick_1ms_i(tick), .ref_pulse_i(refp),
    .freq_a_i(fa), .freq_b_i(fb), .pilot_i(pil),
    .count_o(count), .busy_o(busy), .over_o(over)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_start(input logic [2:0] s, input logic [1:0] g);
    start = 1'b1; ssel = s; gsel = g;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic tick1();
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic pulses(input int na, input int nb, input int nr);
    int m;
    m = (na > nb) ? na : nb;
    m = (nr > m) ? nr : m;
    for (int i = 0; i < m; i++) begin
      fa = (i < na); fb = (i < nb); refp = (i < nr);
      @(negedge clk);
      refp = 1'b0;
      cyc(2);
      fa = 1'b0; fb = 1'b0;
      cyc(3);
    end
  endtask

  task automatic run_freq(input logic [2:0] s, input logic [1:0] g,
                          input int na, input int nb, input int exp_cnt, input bit exp_ovr);
    int n;
    int held;
    n = 1 << (2 * g);
    do_start(s, g);
    pulses(2, 1, 0);                 // before window opens: ignored
    cyc(3);
    tick1();
    cyc(2);
    pulses(na, nb, 0);
    cyc(4);
    for (int t = 1; t <= n; t++) begin
      if (t == n) chk(busy == 1'b1, "R3 busy before last tick", busy, 1);
      tick1();
      if (t < n) cyc(2);
    end
    chk(busy == 1'b0, "R3 busy after last tick", busy, 0);
    chk(count == W'(exp_cnt), "R4 frequency count", count, exp_cnt);
    chk(over == exp_ovr, "R7 overflow flag", over, exp_ovr);
    held = count;
    pulses(2, 2, 2);                 // after window: ignored
    cyc(4);
    chk(count == W'(held), "R4 edges after window ignored", count, held);
  endtask

  task automatic run_period(input logic [2:0] s, input int nr, input int na);
    do_start(s, 2'd0);
    pil = 1'b1; cyc(4); pil = 1'b0; cyc(4);   // before tick: ignored
    tick1();
    cyc(2);
    pulses(na, 0, 3);                // refs before first pilot edge: ignored
    pil = 1'b1; cyc(6); pil = 1'b0; cyc(2);
    pulses(na, 0, nr);
    tick1();                          // tick must not end period
    cyc(2);
    chk(busy == 1'b1, "R5 busy during period", busy, 1);
    cyc(3);
    pil = 1'b1; cyc(5);
    chk(busy == 1'b0, "R5 busy after second pilot edge", busy, 0);
    chk(count == W'(nr), "R5 period count", count, nr);
    pil = 1'b0; cyc(3);
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(2);
    chk(count == '0, "R1 reset count", count, 0);
    chk(busy == 1'b0, "R1 reset busy", busy, 0);
    chk(over == 1'b0, "R1 reset over", over, 0);

    // R3/R4/R6 sweep: all gate codes, both frequency sources
    for (int g = 0; g < 4; g++) begin
      run_freq(3'b010, 2'(g), 3 + 5 * g, 7, 3 + 5 * g, 1'b0);
      run_freq(3'b100, 2'(g), 6, 4 + 3 * g, 4 + 3 * g, 1'b0);
    end

    // R6 priority A over B, and no source selected
    run_freq(3'b110, 2'd0, 5, 9, 5, 1'b0);
    run_freq(3'b000, 2'd1, 5, 9, 0, 1'b0);

    // R5 period mode, R6 pilot wins over A/B
    run_period(3'b001, 11, 0);
    run_period(3'b111, 6, 4);

    // R8 config sampled only at start
    do_start(3'b010, 2'd1);
    gsel = 2'd3; ssel = 3'b100;
    tick1(); cyc(2);
    pulses(4, 2, 0); cyc(4);
    for (int t = 1; t <= 4; t++) begin tick1(); cyc(1); end
    chk(busy == 1'b0, "R8 gate length from start cycle", busy, 0);
    chk(count == W'(4), "R8 source from start cycle", count, 4);

    // R2 restart while busy
    do_start(3'b010, 2'd0);
    tick1(); cyc(2);
    pulses(5, 0, 0);
    do_start(3'b010, 2'd0);
    chk(count == '0, "R2 restart clears count", count, 0);
    chk(busy == 1'b1, "R2 restart busy", busy, 1);
    cyc(2); tick1(); cyc(2);
    pulses(3, 0, 0); cyc(4);
    tick1();
    chk(count == W'(3), "R2 count after restart", count, 3);

    // R7 saturation boundary
    run_freq(3'b010, 2'd0, MAX, 0, MAX, 1'b0);
    run_freq(3'b010, 2'd0, MAX + 1, 0, MAX, 1'b1);
    cyc(10);
    chk(over == 1'b1, "R7 over sticky while idle", over, 1);
    run_freq(3'b010, 2'd0, MAX + 40, 0, MAX, 1'b1);

    // R8 idle hold, then R2 clear of over
    pulses(6, 6, 6); pil = 1'b1; cyc(5); pil = 1'b0; tick1(); cyc(3);
    chk(count == W'(MAX), "R8 idle count hold", count, MAX);
    chk(busy == 1'b0, "R8 idle busy", busy, 0);
    do_start(3'b010, 2'd0);
    chk(over == 1'b0, "R2 start clears over", over, 0);
    chk(count == '0, "R2 start clears count", count, 0);
    tick1(); cyc(2); tick1(); cyc(2);
    chk(busy == 1'b0, "R3 single tick window", busy, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule